// File: doc/BRIEF.md
# Three-Wire Converter Host Reader

This block is the host side of a serial link to one 16-bit sampling converter. The converter runs in its chip-select mode with its serial input strapped high and with no busy indication. The block needs three signals: a convert/select line it drives, a serial clock it drives, and the converter's data line, which it samples. It runs from the system clock. A one-cycle request starts a conversion. The block then waits out the converter's worst-case conversion time with a counter, because nothing tells it when the conversion is finished.

The convert line does three jobs. Its rising edge starts the conversion. Its fall enables the read, and at that point the most significant bit is already on the data line. Raising it again closes the frame. After the fall, the block issues serial clock pulses and captures one bit at each falling edge, most significant bit first. When the last bit is in, it presents the word with a one-cycle valid strobe. Parameters set the wait length, the serial-clock half period, how many bits a frame reads (a short frame is closed early by the convert line) and the minimum high time before another request is taken.

Top module: `adc3w_reader`

## Requirements
- R1: While reset is asserted, and after reset until the first request, `conv_o`, `sck_o` and `valid_o` are low and `data_o` is zero.
- R2: A request seen in the idle state drives `conv_o` high from the next cycle. It stays high for exactly CONV_CYCLES clock cycles, and `sck_o` stays low throughout.
- R3: When `conv_o` falls, `sck_o` stays low for SCK_HALF more cycles before its first rising edge.
- R4: While `conv_o` is low, exactly FRAME_BITS serial-clock pulses are issued, each high for SCK_HALF cycles and separated by SCK_HALF low cycles.
- R5: At the clock edge where `sck_o` goes from high to low, `sdo_i` is captured with the value it had before that edge. The first bit captured is the most significant and lands in bit 15 of `data_o` (in general bit DATA_W-1).
- R6: On the same edge as the last falling serial-clock edge, `conv_o` rises and `valid_o` pulses high for exactly one cycle. `data_o` then holds the captured bits left-aligned, and bits below the captured ones are zero when FRAME_BITS is less than DATA_W.
- R7: After the frame, `conv_o` stays high for exactly GAP_CYCLES cycles and then returns low. A request during that time has no effect.
- R8: A request while converting or reading has no effect on timing or on the result.
- R9: `sck_o` is low whenever `conv_o` is high.
- R10: `data_o` changes only in the cycle where `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Sample request, taken only when idle |
| conv_o | output | 1 | Convert/select line to the converter |
| sck_o | output | 1 | Serial clock to the converter, idle low |
| sdo_i | input | 1 | Serial data from the converter |
| data_o | output | DATA_W | Last captured word, left-aligned |
| valid_o | output | 1 | One-cycle strobe when a new word is presented |

## Verification
On every cycle, the assertions check that the serial clock is quiet while the convert line is high. They also check that each high phase of the convert line lasts exactly the conversion or gap length, that the frame ends after exactly the configured number of falling edges, that the valid strobe coincides with the convert line's rise and lasts one cycle, and that the output word is stable between strobes. Only the bench's scenarios can show that the captured word matches what a converter model shifted out, that a short frame zero-fills the low bits, and that requests landing in the conversion, read or gap phases are ignored. The bench sweeps walking-one, walking-zero, constant and arithmetic data patterns through a short-frame instance and a full-frame instance.

// File: rtl/adc3w_pkg.sv
// Shared definitions for the three-wire converter host reader.
// Assumes nothing beyond a single clock domain.
package adc3w_pkg;

    // Frame sequencer phases
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_READ = 2'd2,
        ST_GAP  = 2'd3
    } rd_state_t;

    // Larger of two integers, used to size shared counters
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc3w_timer.sv
// Down-counter for phase timing. A load sets the count, and the count then
// decrements once per cycle until it reaches zero, where it holds.
// Assumes load values fit in W bits.
module adc3w_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // Load or count down toward zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc3w_sck_gen.sv
// Serial-clock generator. While run_i is high, it produces pulses that
// start low for HALF cycles and then alternate HALF cycles high and low.
// It flags each falling edge and the last one of a frame of BITS pulses.
// Assumes run_i drops in the cycle after last_o.
module adc3w_sck_gen #(
    parameter int HALF = 2,
    parameter int BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sck_o,
    output logic fall_o,
    output logic last_o
);

    localparam int HC_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BC_W = $clog2(BITS + 1);
    localparam logic [HC_W-1:0] HC_RELOAD = HC_W'(HALF - 1);
    localparam logic [BC_W-1:0] BC_LAST   = BC_W'(BITS - 1);

    logic [HC_W-1:0] half_q;
    logic [BC_W-1:0] bits_q;
    logic            sck_q;
    logic            toggle;

    assign toggle = run_i && (half_q == '0);
    assign fall_o = toggle && sck_q;
    assign last_o = fall_o && (bits_q == BC_LAST);
    assign sck_o  = sck_q;

    // Half-period counter and serial-clock level
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            half_q <= HC_RELOAD;
            sck_q  <= 1'b0;
        end else if (toggle) begin
            half_q <= HC_RELOAD;
            sck_q  <= ~sck_q;
        end else begin
            half_q <= half_q - 1'b1;
        end
    end

    // Count falling edges within the frame
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            bits_q <= '0;
        end else if (fall_o) begin
            bits_q <= bits_q + 1'b1;
        end
    end

endmodule

// File: rtl/adc3w_shifter.sv
// MSB-first capture register. Shifts one bit in per enable and presents
// the word that the next shift would form, left-aligned in DATA_W bits.
// Assumes 2 <= BITS <= DATA_W.
module adc3w_shifter #(
    parameter int DATA_W = 16,
    parameter int BITS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              din_i,
    output logic [DATA_W-1:0] word_next_o
);

    logic [BITS-1:0] sh_q;
    logic [BITS-1:0] frame_next;

    assign frame_next = {sh_q[BITS-2:0], din_i};

    // Shift captured bits toward the MSB
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (shift_i) begin
            sh_q <= frame_next;
        end
    end

    // Left-align, zero-filling below a short frame
    generate
        if (BITS == DATA_W) begin : g_full
            assign word_next_o = frame_next;
        end else begin : g_short
            assign word_next_o = {frame_next, {(DATA_W - BITS){1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/adc3w_reader.sv
// Host-side reader for one converter in three-wire select mode with no
// busy indication. A request raises the convert line and waits CONV_CYCLES
// for the worst-case conversion. The line then drops, and FRAME_BITS
// serial-clock pulses capture data MSB first on falling edges. The line
// rises again to end the frame and is held high for GAP_CYCLES.
// Assumes sdo_i is already timed to clk and the converter's serial input
// is tied high.
module adc3w_reader #(
    parameter int DATA_W      = 16,
    parameter int FRAME_BITS  = 16,
    parameter int CONV_CYCLES = 200,
    parameter int SCK_HALF    = 2,
    parameter int GAP_CYCLES  = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    output logic              conv_o,
    output logic              sck_o,
    input  logic              sdo_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    import adc3w_pkg::*;

    localparam int TMR_W = $clog2(max2(CONV_CYCLES, GAP_CYCLES) + 1);
    localparam logic [TMR_W-1:0] CONV_LOAD = TMR_W'(CONV_CYCLES - 1);
    localparam logic [TMR_W-1:0] GAP_LOAD  = TMR_W'(GAP_CYCLES - 1);

    rd_state_t         state_q;
    logic              conv_q;
    logic              valid_q;
    logic [DATA_W-1:0] data_q;

    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              sck_run;
    logic              bit_fall;
    logic              bit_last;
    logic [DATA_W-1:0] word_next;
    logic              start;

    assign start    = (state_q == ST_IDLE) && req_i;
    assign sck_run  = (state_q == ST_READ);
    assign tmr_load = start || bit_last;
    assign tmr_val  = start ? CONV_LOAD : GAP_LOAD;

    adc3w_timer #(.W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    adc3w_sck_gen #(.HALF(SCK_HALF), .BITS(FRAME_BITS)) u_sck (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (sck_run),
        .sck_o  (sck_o),
        .fall_o (bit_fall),
        .last_o (bit_last)
    );

    adc3w_shifter #(.DATA_W(DATA_W), .BITS(FRAME_BITS)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_i     (bit_fall),
        .din_i       (sdo_i),
        .word_next_o (word_next)
    );

    // Frame sequencer: convert line, result register and strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            conv_q  <= 1'b0;
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (req_i) begin
                    state_q <= ST_CONV;
                    conv_q  <= 1'b1;
                end
                ST_CONV: if (tmr_zero) begin
                    state_q <= ST_READ;
                    conv_q  <= 1'b0;
                end
                ST_READ: if (bit_last) begin
                    state_q <= ST_GAP;
                    conv_q  <= 1'b1;
                    valid_q <= 1'b1;
                    data_q  <= word_next;
                end
                ST_GAP: if (tmr_zero) begin
                    state_q <= ST_IDLE;
                    conv_q  <= 1'b0;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign conv_o  = conv_q;
    assign valid_o = valid_q;
    assign data_o  = data_q;

endmodule

// File: rtl/adc3w_reader_chk.sv
// Protocol checker for adc3w_reader, attached by bind. It watches only the
// ports and keeps its own counters for phase lengths and edge counts.
module adc3w_reader_chk #(
    parameter int DATA_W      = 16,
    parameter int FRAME_BITS  = 16,
    parameter int CONV_CYCLES = 200,
    parameter int GAP_CYCLES  = 50
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_o,
    input logic              sck_o,
    input logic              valid_o,
    input logic [DATA_W-1:0] data_o
);

    int   hi_cnt;
    int   fall_cnt;
    logic in_gap;
    logic sck_prev;
    logic fall_now;

    assign fall_now = sck_prev && !sck_o;

    // Track length of each convert-high phase and whether it is the gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= 0;
            in_gap <= 1'b0;
        end else begin
            hi_cnt <= conv_o ? hi_cnt + 1 : 0;
            if (valid_o)      in_gap <= 1'b1;
            else if (!conv_o) in_gap <= 1'b0;
        end
    end

    // Count serial-clock falls within a read phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            fall_cnt <= 0;
        end else begin
            sck_prev <= sck_o;
            if (conv_o)        fall_cnt <= 0;
            else if (fall_now) fall_cnt <= fall_cnt + 1;
        end
    end

    AST_SCK_QUIET_CNV_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        conv_o |-> !sck_o); // R9

    AST_CONV_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(conv_o) && !in_gap) |-> (hi_cnt == CONV_CYCLES)); // R2

    AST_GAP_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(conv_o) && in_gap) |-> (hi_cnt == GAP_CYCLES)); // R7

    AST_FIRST_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_o) |-> !sck_o); // R3

    AST_FRAME_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (fall_cnt + (fall_now ? 1 : 0) == FRAME_BITS)); // R4

    AST_VALID_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $rose(conv_o)); // R6

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R6

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(data_o)); // R10

endmodule

bind adc3w_reader adc3w_reader_chk #(
    .DATA_W      (DATA_W),
    .FRAME_BITS  (FRAME_BITS),
    .CONV_CYCLES (CONV_CYCLES),
    .GAP_CYCLES  (GAP_CYCLES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .conv_o  (conv_o),
    .sck_o   (sck_o),
    .valid_o (valid_o),
    .data_o  (data_o)
);

// File: tb/adc3w_reader_bench.sv
`timescale 1ns/1ps

// Behavioural converter: the MSB appears when the convert line falls, and
// the output advances on each serial-clock fall while the line is low.
module adc3w_conv_model (
    input  logic        cnv,
    input  logic        sck,
    input  logic [15:0] word,
    output logic        sdo
);
    int   idx = 15;
    logic cnv_d = 1'b0;
    logic sck_d = 1'b0;

    always @(cnv or sck) begin
        if (cnv_d && !cnv) idx = 15;
        else if (sck_d && !sck && !cnv) idx = idx - 1;
        cnv_d = cnv;
        sck_d = sck;
    end

    assign sdo = (!cnv && idx >= 0 && idx < 16) ? word[idx[3:0]] : 1'b0;
endmodule

module adc3w_reader_bench;
    localparam int CONV = 5;
    localparam int HALF = 2;
    localparam int GAP  = 3;
    localparam int FB   = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_full = 1'b0;
    logic [15:0] cur_word = '0;
    logic        conv, sck, sdo, valid;
    logic [15:0] data;
    logic        conv_f, sck_f, sdo_f, valid_f;
    logic [15:0] data_f;

    int checks = 0;
    int errors = 0;
    int frames = 0;
    int full_valids = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    adc3w_reader #(.DATA_W(16), .FRAME_BITS(FB), .CONV_CYCLES(CONV),
                   .SCK_HALF(HALF), .GAP_CYCLES(GAP)) u_adc3w_reader (
        .clk(clk), .rst_n(rst_n), .req_i(req), .conv_o(conv), .sck_o(sck),
        .sdo_i(sdo), .data_o(data), .valid_o(valid));

    adc3w_conv_model u_model (.cnv(conv), .sck(sck), .word(cur_word), .sdo(sdo));

    adc3w_reader #(.DATA_W(16), .FRAME_BITS(16), .CONV_CYCLES(4),
                   .SCK_HALF(1), .GAP_CYCLES(2)) u_adc3w_reader_full (
        .clk(clk), .rst_n(rst_n), .req_i(req_full), .conv_o(conv_f), .sck_o(sck_f),
        .sdo_i(sdo_f), .data_o(data_f), .valid_o(valid_f));

    adc3w_conv_model u_model_f (.cnv(conv_f), .sck(sck_f), .word(cur_word), .sdo(sdo_f));

    task automatic chk(input bit ok, input string req_tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req_tag, act, exp, $time);
        end
    endtask

    // Full-frame instance: every strobe must carry the whole word (R5, R6)
    always @(negedge clk) begin
        if (rst_n && valid_f) begin
            full_valids++;
            chk(data_f == cur_word, "R5 full frame", data_f, cur_word);
        end
    end

    task automatic run_frame(input logic [15:0] w);
        logic [15:0] exp;
        exp = w & 16'hFFF0;
        cur_word = w;
        frames++;
        @(negedge clk) begin req = 1'b1; req_full = 1'b1; end
        @(negedge clk) begin req = 1'b0; req_full = 1'b0; end
        for (int i = 0; i < CONV; i++) begin
            chk(conv == 1'b1, "R2 conv high", conv, 1);
            chk(sck == 1'b0, "R9 sck quiet", sck, 0);
            req = (i == 1);                 // R8 stray request
            @(negedge clk);
        end
        req = 1'b0;
        for (int h = 0; h < HALF; h++) begin
            chk(conv == 1'b0 && sck == 1'b0, "R3 msb setup", {conv, sck}, 0);
            @(negedge clk);
        end
        for (int b = 0; b < FB; b++) begin
            for (int h = 0; h < HALF; h++) begin
                chk(sck == 1'b1 && conv == 1'b0, "R4 sck high", {conv, sck}, 1);
                req = (b == 3 && h == 0);   // R8 stray request
                @(negedge clk);
            end
            req = 1'b0;
            if (b < FB - 1) begin
                for (int h = 0; h < HALF; h++) begin
                    chk(sck == 1'b0 && valid == 1'b0, "R4 sck low", {valid, sck}, 0);
                    @(negedge clk);
                end
            end
        end
        chk(conv == 1'b1 && sck == 1'b0, "R6 frame end", {conv, sck}, 2);
        chk(valid == 1'b1, "R6 valid", valid, 1);
        chk(data == exp, "R5 R6 data", data, exp);
        @(negedge clk);
        chk(valid == 1'b0, "R6 one cycle", valid, 0);
        for (int g = 1; g < GAP; g++) begin
            chk(conv == 1'b1, "R7 gap high", conv, 1);
            req = 1'b1;                     // R7 ignored during gap
            @(negedge clk);
        end
        req = 1'b0;
        for (int k = 0; k < 30; k++) begin
            chk(conv == 1'b0 && sck == 1'b0, "R7 R8 idle", {conv, sck}, 0);
            chk(data == exp, "R10 hold", data, exp);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(conv == 0 && sck == 0 && valid == 0 && data == 0, "R1 in reset",
            {data, 1'b0, conv, sck, valid}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(conv == 0 && sck == 0 && valid == 0 && data == 0, "R1 after reset",
            {data, 1'b0, conv, sck, valid}, 0);
        run_frame(16'h0000);
        run_frame(16'hFFFF);
        for (int s = 0; s < 16; s++) run_frame(16'(1 << s));
        for (int s = 0; s < 16; s++) run_frame(~16'(1 << s));
        for (int s = 0; s < 8; s++) run_frame(16'(s * 40503 + 4660));
        chk(full_valids == frames, "R6 full strobes", full_valids, frames);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule